// File: doc/BRIEF.md
# Clocked Synchronous Serial Transceiver

This block is a full-duplex serial port that is the clock master of its link. It generates the serial clock from the system clock and moves 8-bit characters in both directions at once. The transmit side has a holding register ahead of its shift register, and so does the receive side. Software can therefore queue the next byte or collect the previous one while a character is on the wire. When the next byte is queued in time, characters follow one another with no gap in the serial clock.

The serial clock rests high. Every transfer of a bit begins with a falling edge, which puts the next data bit on the output line. The partner samples that bit on the following rising edge, and the block samples its own input line on that same rising edge. A character has no framing bits: it is eight data bits and nothing else. The clock runs only while characters are being moved.

Top module: `sync_serial_xcvr`

## Requirements
- R1: A character is exactly 8 data bits with no start or stop bits, and the bits go out least significant bit first: bit 0 appears after the first falling edge and bit 7 after the eighth.
- R2: `sclk_o` is 1 out of reset and while idle. While it runs, each low phase and each high phase lasts `div_i`+1 system clocks, so the full period is 2×(`div_i`+1).
- R3: `sdo_o` changes only in the cycle where `sclk_o` falls, and it keeps its value from that edge until the next falling edge.
- R4: `tx_empty_o` is 1 out of reset. It drops to 0 in the cycle after a `tx_wr_i` pulse. When the shifter is idle, the next cycle moves the byte into the shifter: `sclk_o` falls, `sdo_o` shows bit 0, and `tx_empty_o` returns to 1. `tx_empty_o` only ever rises together with a falling `sclk_o`.
- R5: `sdi_i` is sampled on each rising edge of `sclk_o`, least significant bit first. On the 8th rising edge the assembled byte appears on `rx_data_o` and `rx_full_o` rises in that same cycle.
- R6: If a byte is waiting when a character ends, its first falling edge comes `div_i`+1 cycles after the 8th rising edge. Three queued characters therefore span exactly 47×(`div_i`+1) cycles, measured from the first falling edge to the last rising edge.
- R7: If `rx_full_o` is still 1 at the 8th rising edge of a character, `rx_ovr_o` becomes 1, the new byte is dropped, and `rx_data_o` keeps the earlier byte.
- R8: If no byte is waiting when a character ends, `sclk_o` stays high and `sdo_o` keeps the last bit sent (bit 7) until the next write.
- R9: A one-cycle `rx_rd_i` pulse clears both `rx_full_o` and `rx_ovr_o` in the next cycle.
- R10: Reception runs during every transmitted character: each character sent also brings in one byte from `sdi_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| div_i | input | DIV_W | Half-period divider; each serial clock phase lasts div_i+1 cycles |
| tx_wr_i | input | 1 | Write strobe for the transmit holding register |
| tx_data_i | input | 8 | Byte to transmit |
| tx_empty_o | output | 1 | Transmit holding register can accept a byte |
| rx_rd_i | input | 1 | Read strobe; acknowledges the received byte |
| rx_data_o | output | 8 | Last accepted received byte |
| rx_full_o | output | 1 | Received byte waiting to be read |
| rx_ovr_o | output | 1 | A byte was dropped because the previous one was unread |
| sclk_o | output | 1 | Serial clock, idle high |
| sdo_o | output | 1 | Serial data out, changes on falling edges |
| sdi_i | input | 1 | Serial data in, sampled on rising edges |

## Verification
The assertions check the edge relationships on every cycle:
- the data line moves only together with a falling clock;
- the transmit-empty flag rises only when the shifter loads;
- the receive-full flag rises only on a rising clock;
- an overrun leaves the held byte untouched.

The bench scenarios cover what a single cycle cannot show:
- the exact length of each clock phase;
- gap-free chaining of queued characters;
- the clock stopping high after the last character;
- bit order and byte values in both directions under several divider settings.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
    localparam int CHAR_W = 8;
    localparam int CNT_W  = $clog2(CHAR_W);

    typedef logic [CHAR_W-1:0] char_t;

    typedef struct packed {
        char_t            hold;
        logic             hold_vld;
        char_t            shreg;
        logic [CNT_W-1:0] bit_idx;
        logic             sclk;
        logic             sdo;
        logic             busy;
    } tx_state_t;

    typedef struct packed {
        char_t shreg;
        char_t hold;
        logic  full;
        logic  ovr;
    } rx_state_t;
endpackage

// File: rtl/ssx_phase_timer.sv
module ssx_phase_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == div);
        cnt_d = (!run || tick) ? '0 : DIV_W'(cnt_q + 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/ssx_tx.sv
module ssx_tx
    import ssx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick,
    input  logic  wr,
    input  char_t wdata,
    output logic  sclk,
    output logic  sdo,
    output logic  busy,
    output logic  empty,
    output logic  rise,
    output logic  last
);
    tx_state_t s_d, s_q;

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CHAR_W - 1);

    always_comb begin
        s_d  = s_q;
        rise = 1'b0;
        last = 1'b0;
        if (!s_q.busy) begin
            if (s_q.hold_vld) begin
                s_d.shreg    = s_q.hold;
                s_d.sdo      = s_q.hold[0];
                s_d.bit_idx  = '0;
                s_d.sclk     = 1'b0;
                s_d.busy     = 1'b1;
                s_d.hold_vld = 1'b0;
            end
        end else if (tick) begin
            if (!s_q.sclk) begin
                s_d.sclk = 1'b1;
                rise     = 1'b1;
                last     = (s_q.bit_idx == LAST_IDX);
            end else if (s_q.bit_idx == LAST_IDX) begin
                if (s_q.hold_vld) begin
                    s_d.shreg    = s_q.hold;
                    s_d.sdo      = s_q.hold[0];
                    s_d.bit_idx  = '0;
                    s_d.sclk     = 1'b0;
                    s_d.hold_vld = 1'b0;
                end else begin
                    s_d.busy = 1'b0;
                end
            end else begin
                s_d.sclk    = 1'b0;
                s_d.shreg   = s_q.shreg >> 1;
                s_d.sdo     = s_q.shreg[1];
                s_d.bit_idx = s_q.bit_idx + 1'b1;
            end
        end
        if (wr) begin
            s_d.hold     = wdata;
            s_d.hold_vld = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.sclk <= 1'b1;
            s_q.sdo  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign sclk  = s_q.sclk;
    assign sdo   = s_q.sdo;
    assign busy  = s_q.busy;
    assign empty = !s_q.hold_vld;
endmodule

// File: rtl/ssx_rx.sv
module ssx_rx
    import ssx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  rise,
    input  logic  last,
    input  logic  sdi,
    input  logic  rd,
    output char_t data,
    output logic  full,
    output logic  ovr
);
    rx_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (rd) begin
            s_d.full = 1'b0;
            s_d.ovr  = 1'b0;
        end
        if (rise) begin
            s_d.shreg = {sdi, s_q.shreg[CHAR_W-1:1]};
            if (last) begin
                if (s_d.full) begin
                    s_d.ovr = 1'b1;
                end else begin
                    s_d.hold = s_d.shreg;
                    s_d.full = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign data = s_q.hold;
    assign full = s_q.full;
    assign ovr  = s_q.ovr;
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
    import ssx_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    input  logic             tx_wr_i,
    input  logic [7:0]       tx_data_i,
    output logic             tx_empty_o,
    input  logic             rx_rd_i,
    output logic [7:0]       rx_data_o,
    output logic             rx_full_o,
    output logic             rx_ovr_o,
    output logic             sclk_o,
    output logic             sdo_o,
    input  logic             sdi_i
);
    logic tick, busy, rise, last;

    ssx_phase_timer #(.DIV_W(DIV_W)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .div  (div_i),
        .tick (tick)
    );

    ssx_tx u_tx (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .wr   (tx_wr_i),
        .wdata(tx_data_i),
        .sclk (sclk_o),
        .sdo  (sdo_o),
        .busy (busy),
        .empty(tx_empty_o),
        .rise (rise),
        .last (last)
    );

    ssx_rx u_rx (
        .clk  (clk),
        .rst_n(rst_n),
        .rise (rise),
        .last (last),
        .sdi  (sdi_i),
        .rd   (rx_rd_i),
        .data (rx_data_o),
        .full (rx_full_o),
        .ovr  (rx_ovr_o)
    );
endmodule

// File: rtl/ssx_checker.sv
module ssx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sclk,
    input logic       sdo,
    input logic       tx_empty,
    input logic       rx_full,
    input logic       rx_ovr,
    input logic [7:0] rx_data
);
    AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo) |-> $fell(sclk)); // R3
    AST_EMPTY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_empty) |-> $fell(sclk)); // R4
    AST_FULL_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> $rose(sclk)); // R5
    AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ovr) |-> ($past(rx_full) && $rose(sclk))); // R7
    AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ovr) |-> $stable(rx_data)); // R7
endmodule

bind sync_serial_xcvr ssx_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk    (sclk_o),
    .sdo     (sdo_o),
    .tx_empty(tx_empty_o),
    .rx_full (rx_full_o),
    .rx_ovr  (rx_ovr_o),
    .rx_data (rx_data_o)
);

// File: tb/sync_serial_xcvr_bench.sv
module sync_serial_xcvr_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div_r = 8'd2;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       rx_rd = 1'b0;
    logic       sdi = 1'b0;
    logic       tx_empty_o, rx_full_o, rx_ovr_o, sclk_o, sdo_o;
    logic [7:0] rx_data_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [7:0] rx_src [0:63];
    logic [7:0] tx_arr [0:63];
    logic [7:0] cap_arr [0:63];
    int start_cyc [0:63];
    int end_cyc   [0:63];
    int tx_cnt = 0, cap_cnt = 0, fall_cnt = 0, n_rx = 0;

    sync_serial_xcvr #(.DIV_W(8)) u_sync_serial_xcvr (
        .clk(clk), .rst_n(rst_n), .div_i(div_r),
        .tx_wr_i(tx_wr), .tx_data_i(tx_data), .tx_empty_o(tx_empty_o),
        .rx_rd_i(rx_rd), .rx_data_o(rx_data_o), .rx_full_o(rx_full_o),
        .rx_ovr_o(rx_ovr_o), .sclk_o(sclk_o), .sdo_o(sdo_o), .sdi_i(sdi)
    );

    always #5 clk = ~clk;
    initial forever begin @(posedge clk); cyc++; end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic int half_len();
        return int'(div_r) + 1;
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // line monitor: phase lengths, data stability, capture of sdo, drive of sdi
    initial begin
        logic prev_sclk, prev_sdo, fell, rose;
        logic [7:0] cap;
        int low_len, rbits;
        prev_sclk = 1'b1; prev_sdo = 1'b1; low_len = 0; rbits = 0; cap = '0;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            fell = prev_sclk && !sclk_o;
            rose = !prev_sclk && sclk_o;
            if (sdo_o !== prev_sdo) chk(fell, "R3", int'(sdo_o), int'(prev_sdo));
            if (!sclk_o) low_len++;
            if (rose) begin
                chk(low_len == half_len(), "R2 low phase", low_len, half_len());
                low_len = 0;
                cap = {sdo_o, cap[7:1]};
                rbits++;
                if (rbits == 8) begin
                    cap_arr[cap_cnt] = cap;
                    end_cyc[cap_cnt] = cyc;
                    cap_cnt++;
                    rbits = 0;
                end
            end
            if (fell) begin
                if (fall_cnt % 8 == 0) start_cyc[fall_cnt / 8] = cyc;
                sdi = rx_src[(fall_cnt / 8) % 64][fall_cnt % 8];
                fall_cnt++;
            end
            prev_sclk = sclk_o;
            prev_sdo  = sdo_o;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", cyc, 0);
        finish_run();
    end

    task automatic write_tx(input logic [7:0] b);
        @(negedge clk);
        while (!tx_empty_o) @(negedge clk);
        tx_wr = 1'b1; tx_data = b;
        tx_arr[tx_cnt] = b; tx_cnt++;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic read_rx(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            while (!rx_full_o) @(negedge clk);
            chk(rx_data_o == rx_src[n_rx], "R5 R10 rx byte", rx_data_o, rx_src[n_rx]);
            n_rx++;
            rx_rd = 1'b1;
            @(negedge clk);
            rx_rd = 1'b0;
        end
    endtask

    task automatic wait_idle();
        while (cap_cnt < tx_cnt) @(negedge clk);
        repeat (4 * half_len() + 4) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 64; i++) rx_src[i] = 8'($urandom);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sclk_o == 1'b1, "R2 reset sclk", sclk_o, 1);
        chk(tx_empty_o == 1'b1, "R4 reset empty", tx_empty_o, 1);
        chk(rx_full_o == 1'b0, "R5 reset full", rx_full_o, 0);
        chk(rx_ovr_o == 1'b0, "R7 reset ovr", rx_ovr_o, 0);

        // directed start timing (R4) and stop behaviour (R8)
        div_r = 8'd2;
        tx_wr = 1'b1; tx_data = 8'h35; tx_arr[tx_cnt] = 8'h35; tx_cnt++;
        @(negedge clk);
        tx_wr = 1'b0;
        chk(tx_empty_o == 1'b0, "R4 empty drops", tx_empty_o, 0);
        @(negedge clk);
        chk(sclk_o == 1'b0, "R4 first fall", sclk_o, 0);
        chk(sdo_o == 1'b1, "R4 R1 bit0 out", sdo_o, 1);
        chk(tx_empty_o == 1'b1, "R4 empty back", tx_empty_o, 1);
        read_rx(1);
        wait_idle();
        repeat (30) @(negedge clk);
        chk(sclk_o == 1'b1, "R8 clock parked", sclk_o, 1);
        chk(sdo_o == 1'b0, "R8 last bit held", sdo_o, 0);
        chk(fall_cnt == 8, "R8 no extra edges", fall_cnt, 8);
        chk(cap_arr[0] == 8'h35, "R1 byte", cap_arr[0], 8'h35);

        // back-to-back chaining (R6)
        div_r = 8'd3;
        begin
            int c0;
            c0 = cap_cnt;
            fork
                begin write_tx(8'hC3); write_tx(8'h5A); write_tx(8'h0F); end
                read_rx(3);
            join
            wait_idle();
            chk(end_cyc[c0 + 2] - start_cyc[c0] == 47 * half_len(), "R6 gapless span",
                end_cyc[c0 + 2] - start_cyc[c0], 47 * half_len());
        end

        // overrun (R7) and read clearing (R9)
        div_r = 8'd1;
        write_tx(8'h81); write_tx(8'h7E);
        wait_idle();
        chk(rx_ovr_o == 1'b1, "R7 ovr set", rx_ovr_o, 1);
        chk(rx_full_o == 1'b1, "R7 still full", rx_full_o, 1);
        chk(rx_data_o == rx_src[n_rx], "R7 first byte kept", rx_data_o, rx_src[n_rx]);
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
        chk(rx_full_o == 1'b0, "R9 full cleared", rx_full_o, 0);
        chk(rx_ovr_o == 1'b0, "R9 ovr cleared", rx_ovr_o, 0);
        n_rx += 2;

        // random traffic under several dividers (R1, R2, R5, R10)
        foreach (cap_arr[k]) if (k < 4) begin
            case (k)
                0: div_r = 8'd0;
                1: div_r = 8'd1;
                2: div_r = 8'd4;
                default: div_r = 8'd6;
            endcase
            fork
                for (int j = 0; j < 8; j++) write_tx(8'($urandom));
                read_rx(8);
            join
            wait_idle();
        end

        chk(cap_cnt == tx_cnt, "R1 char count", cap_cnt, tx_cnt);
        for (int i = 0; i < tx_cnt; i++)
            chk(cap_arr[i] == tx_arr[i], "R1 LSB-first byte", cap_arr[i], tx_arr[i]);
        finish_run();
    end
endmodule